// File: doc/BRIEF.md
# Masked Vector Bit-Count Unit

This block counts the one bits in every element of a 512-bit source vector and returns those counts in a 512-bit result. Each operation selects its own element width (8, 16, 32 or 64 bits) and its own active vector length (128, 256 or 512 bits). The number of lanes in an operation is the active length divided by the element width. Each count sits in the low bits of its element and is zero-extended to the full element width.

A per-lane writemask can be enabled. In merge mode a lane whose mask bit is clear keeps the value supplied on the old-destination input. In zero mode that lane is cleared. For 32-bit and 64-bit elements, a broadcast control makes every lane count source element 0 instead of its own element. The block clears every result bit at or above the active length, in all mask modes. The block produces no flags. A result appears one cycle after its input strobe.

Top module: `popc_vec_unit`

## Requirements
- R1: Each active lane of `out_data` holds the count of one bits in its source element, zero-extended in the low bits of the element. The `in_esize` encoding is 00 = 8-bit, 01 = 16-bit, 10 = 32-bit and 11 = 64-bit. Lane j occupies bits [j*W +: W] for element width W.
- R2: The active length is 128 bits for `in_vlen` = 00, 256 bits for 01, and 512 bits for 10 and 11. The lane count is the active length divided by W.
- R3: When `in_mask_en` is 0, every active lane is computed whatever the value of `in_mask`.
- R4: When `in_mask_en` is 1 and `in_zero` is 0, an active lane j with `in_mask[j]` = 0 outputs the matching bits of `in_old`.
- R5: When `in_mask_en` is 1 and `in_zero` is 1, an active lane j with `in_mask[j]` = 0 outputs all zeros.
- R6: With `in_bcast` = 1 and 32-bit or 64-bit elements, every computed lane counts the bits of source element 0.
- R7: With 8-bit or 16-bit elements, `in_bcast` has no effect on the result.
- R8: Result bits from the active length up to bit 511 are zero in every mask mode, including merge mode.
- R9: Mask bits with an index at or above the lane count have no effect on the result.
- R10: `out_valid` is 1 exactly in the cycle after a cycle with `in_valid` = 1, and `out_data` holds that operation's result in that cycle.
- R11: Synchronous reset clears `out_valid` and `out_data`. Without `in_valid`, `out_data` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| in_src | input | 512 | Source vector |
| in_old | input | 512 | Previous destination value, used for merging |
| in_mask | input | 64 | Per-lane writemask, bit j for lane j |
| in_esize | input | 2 | Element width select |
| in_vlen | input | 2 | Active vector length select |
| in_mask_en | input | 1 | Enables the writemask |
| in_zero | input | 1 | 1 = zero masked lanes, 0 = merge |
| in_bcast | input | 1 | Broadcast source element 0 (32/64-bit only) |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| out_data | output | 512 | Result vector |

## Verification
The bench runs merge mode at the 128-bit length with an all-ones old destination. A design that clears the upper bits only in zero mode leaks ones above bit 127 in that case. Broadcast is requested with byte and word sizes, where a design that honours it would repeat lane 0's count across all lanes. Mask vectors with their upper bits set are paired with short lane counts, to catch designs that index the mask by byte position or read out-of-range bits. Full-ones elements exercise the largest counts (8 to 64), so a truncated count field shows up as a wrapped or missing top bit.

// File: rtl/popc_pkg.sv
package popc_pkg;

    typedef enum logic [1:0] {
        ESZ_BYTE  = 2'b00,
        ESZ_WORD  = 2'b01,
        ESZ_DWORD = 2'b10,
        ESZ_QWORD = 2'b11
    } esize_e;

    typedef struct packed {
        esize_e     esize;
        logic [1:0] vlen;
        logic       mask_en;
        logic       zero_mode;
        logic       bcast;
    } popc_ctl_t;

    // number of one bits in one byte
    function automatic logic [3:0] ones_in_byte(input logic [7:0] v);
        logic [3:0] acc;
        acc = '0;
        for (int k = 0; k < 8; k++) begin
            acc = acc + {3'b000, v[k]};
        end
        return acc;
    endfunction

    // active byte count for a length code, clipped to the vector width
    function automatic int unsigned active_bytes(input logic [1:0] vl, input int unsigned nbytes);
        int unsigned n;
        n = 16 << vl;
        if (n > nbytes) n = nbytes;
        return n;
    endfunction

    // broadcast only applies to 32- and 64-bit elements
    function automatic logic bcast_legal(input esize_e sz);
        return (sz == ESZ_DWORD) || (sz == ESZ_QWORD);
    endfunction

endpackage

// File: rtl/popc_operand_mux.sv
module popc_operand_mux
    import popc_pkg::*;
#(
    parameter int VEC_W = 512
) (
    input  logic [VEC_W-1:0] src,
    input  popc_ctl_t        ctl,
    output logic [VEC_W-1:0] eff
);
    localparam int NB = VEC_W / 8;

    logic use_bc;
    assign use_bc = ctl.bcast && bcast_legal(ctl.esize);

    for (genvar b = 0; b < NB; b++) begin : g_byte
        localparam int DW_SRC = (b % 4) * 8;
        localparam int QW_SRC = (b % 8) * 8;
        always_comb begin
            eff[b*8 +: 8] = src[b*8 +: 8];
            if (use_bc) begin
                if (ctl.esize == ESZ_DWORD) eff[b*8 +: 8] = src[DW_SRC +: 8];
                else                        eff[b*8 +: 8] = src[QW_SRC +: 8];
            end
        end
    end

endmodule

// File: rtl/popc_count_tree.sv
module popc_count_tree
    import popc_pkg::*;
#(
    parameter int VEC_W = 512
) (
    input  logic [VEC_W-1:0]         vec,
    output logic [VEC_W/8-1:0][3:0]  cnt8,
    output logic [VEC_W/16-1:0][4:0] cnt16,
    output logic [VEC_W/32-1:0][5:0] cnt32,
    output logic [VEC_W/64-1:0][6:0] cnt64
);
    localparam int NB = VEC_W / 8;

    for (genvar b = 0; b < NB; b++) begin : g_b
        assign cnt8[b] = ones_in_byte(vec[b*8 +: 8]);
    end

    for (genvar h = 0; h < NB/2; h++) begin : g_h
        assign cnt16[h] = {1'b0, cnt8[2*h]} + {1'b0, cnt8[2*h+1]};
    end

    for (genvar w = 0; w < NB/4; w++) begin : g_w
        assign cnt32[w] = {1'b0, cnt16[2*w]} + {1'b0, cnt16[2*w+1]};
    end

    for (genvar d = 0; d < NB/8; d++) begin : g_d
        assign cnt64[d] = {1'b0, cnt32[2*d]} + {1'b0, cnt32[2*d+1]};
    end

endmodule

// File: rtl/popc_lane_writer.sv
module popc_lane_writer
    import popc_pkg::*;
#(
    parameter int VEC_W = 512
) (
    input  popc_ctl_t                ctl,
    input  logic [VEC_W/8-1:0]       mask,
    input  logic [VEC_W-1:0]         old,
    input  logic [VEC_W/8-1:0][3:0]  cnt8,
    input  logic [VEC_W/16-1:0][4:0] cnt16,
    input  logic [VEC_W/32-1:0][5:0] cnt32,
    input  logic [VEC_W/64-1:0][6:0] cnt64,
    output logic [VEC_W-1:0]         res
);
    localparam int NB    = VEC_W / 8;
    localparam int IDX_W = $clog2(NB);

    int unsigned act_n;
    assign act_n = active_bytes(ctl.vlen, NB);

    for (genvar b = 0; b < NB; b++) begin : g_byte
        localparam logic [IDX_W-1:0] BIDX = IDX_W'(b);
        logic [7:0]       cnt_byte;
        logic [IDX_W-1:0] lane;
        logic             active;
        logic             take;

        // count lands only in the lowest byte of its element
        always_comb begin
            cnt_byte = '0;
            unique case (ctl.esize)
                ESZ_BYTE:  cnt_byte = {4'b0, cnt8[b]};
                ESZ_WORD:  if (b % 2 == 0) cnt_byte = {3'b0, cnt16[b/2]};
                ESZ_DWORD: if (b % 4 == 0) cnt_byte = {2'b0, cnt32[b/4]};
                ESZ_QWORD: if (b % 8 == 0) cnt_byte = {1'b0, cnt64[b/8]};
                default:   cnt_byte = '0;
            endcase
        end

        assign lane   = BIDX >> ctl.esize;
        assign active = (b < act_n);
        assign take   = !ctl.mask_en || mask[lane];

        always_comb begin
            if (!active)             res[b*8 +: 8] = '0;
            else if (take)           res[b*8 +: 8] = cnt_byte;
            else if (ctl.zero_mode)  res[b*8 +: 8] = '0;
            else                     res[b*8 +: 8] = old[b*8 +: 8];
        end
    end

endmodule

// File: rtl/popc_vec_unit.sv
module popc_vec_unit
    import popc_pkg::*;
#(
    parameter int VEC_W = 512
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [VEC_W-1:0]   in_src,
    input  logic [VEC_W-1:0]   in_old,
    input  logic [VEC_W/8-1:0] in_mask,
    input  logic [1:0]         in_esize,
    input  logic [1:0]         in_vlen,
    input  logic               in_mask_en,
    input  logic               in_zero,
    input  logic               in_bcast,
    output logic               out_valid,
    output logic [VEC_W-1:0]   out_data
);
    localparam int NB      = VEC_W / 8;
    localparam int MIN_LEN = 128;

    popc_ctl_t ctl;
    always_comb begin
        ctl.esize     = esize_e'(in_esize);
        ctl.vlen      = in_vlen;
        ctl.mask_en   = in_mask_en;
        ctl.zero_mode = in_zero;
        ctl.bcast     = in_bcast;
    end

    logic [VEC_W-1:0]        src_eff;
    logic [NB-1:0][3:0]      cnt8;
    logic [NB/2-1:0][4:0]    cnt16;
    logic [NB/4-1:0][5:0]    cnt32;
    logic [NB/8-1:0][6:0]    cnt64;
    logic [VEC_W-1:0]        res;

    popc_operand_mux #(.VEC_W(VEC_W)) u_mux (
        .src (in_src),
        .ctl (ctl),
        .eff (src_eff)
    );

    popc_count_tree #(.VEC_W(VEC_W)) u_tree (
        .vec   (src_eff),
        .cnt8  (cnt8),
        .cnt16 (cnt16),
        .cnt32 (cnt32),
        .cnt64 (cnt64)
    );

    popc_lane_writer #(.VEC_W(VEC_W)) u_writer (
        .ctl   (ctl),
        .mask  (in_mask),
        .old   (in_old),
        .cnt8  (cnt8),
        .cnt16 (cnt16),
        .cnt32 (cnt32),
        .cnt64 (cnt64),
        .res   (res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) out_data <= res;
        end
    end

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid) else $error("valid lost"); // R10
    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid)) else $error("spurious valid"); // R10
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_data)) else $error("data moved while idle"); // R11
    AST_TAIL_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_vlen == 2'b00) |=> (out_data[VEC_W-1:MIN_LEN] == '0)) else $error("tail not cleared"); // R8
    AST_MERGE_LANE0: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_mask_en && !in_zero && !in_mask[0]) |=> (out_data[7:0] == $past(in_old[7:0]))) else $error("merge lost"); // R4
    AST_ZERO_LANE0: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_mask_en && in_zero && !in_mask[0]) |=> (out_data[7:0] == 8'h00)) else $error("zeroing lost"); // R5
    AST_UNMASKED_BYTE0: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_mask_en && in_esize == 2'b00) |=> (out_data[7:0] == 8'($countones($past(in_src[7:0]))))) else $error("byte count"); // R1

endmodule

// File: tb/tb_popc_vec_unit.sv
module tb_popc_vec_unit;
    localparam int CLK_PERIOD = 10;
    localparam int VW = 512;

    logic          clk = 1'b0;
    logic          rst;
    logic          in_valid;
    logic [VW-1:0] in_src, in_old;
    logic [63:0]   in_mask;
    logic [1:0]    in_esize, in_vlen;
    logic          in_mask_en, in_zero, in_bcast;
    logic          out_valid;
    logic [VW-1:0] out_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    popc_vec_unit dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_src(in_src), .in_old(in_old),
        .in_mask(in_mask), .in_esize(in_esize), .in_vlen(in_vlen), .in_mask_en(in_mask_en),
        .in_zero(in_zero), .in_bcast(in_bcast), .out_valid(out_valid), .out_data(out_data)
    );

    int n_run = 0;
    int n_fail = 0;
    logic [VW-1:0] exp_q[$];
    string         tag_q[$];

    function automatic logic [VW-1:0] model(
        input logic [VW-1:0] s, input logic [VW-1:0] o, input logic [63:0] m,
        input int sz, input int vl, input bit men, input bit zm, input bit bc);
        logic [VW-1:0] r;
        int ew, len, lanes, cnt, base, sbase;
        r = '0;
        ew = 8 << sz;
        len = (vl == 0) ? 128 : (vl == 1) ? 256 : 512;
        lanes = len / ew;
        for (int j = 0; j < lanes; j++) begin
            base = j * ew;
            sbase = (bc && sz >= 2) ? 0 : base;
            cnt = 0;
            for (int k = 0; k < ew; k++) cnt += s[sbase + k];
            if (!men || m[j]) begin
                for (int k = 0; k < ew; k++) r[base + k] = (k < 8) ? cnt[k] : 1'b0;
            end else if (!zm) begin
                for (int k = 0; k < ew; k++) r[base + k] = o[base + k];
            end
        end
        return r;
    endfunction

    function automatic logic [VW-1:0] rnd512();
        logic [VW-1:0] v;
        for (int i = 0; i < VW/32; i++) v[i*32 +: 32] = $urandom;
        return v;
    endfunction

    task automatic issue(input string tag, input logic [VW-1:0] s, input logic [VW-1:0] o,
                         input logic [63:0] m, input int sz, input int vl,
                         input bit men, input bit zm, input bit bc);
        @(negedge clk);
        in_valid = 1'b1; in_src = s; in_old = o; in_mask = m;
        in_esize = 2'(sz); in_vlen = 2'(vl); in_mask_en = men; in_zero = zm; in_bcast = bc;
        exp_q.push_back(model(s, o, m, sz, vl, men, zm, bc));
        tag_q.push_back(tag);
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
        in_src = rnd512();
    endtask

    // monitor: compare every produced result with the oldest expectation
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            n_run++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R10: unexpected out_valid, actual=1 expected=0");
            end else begin
                logic [VW-1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (out_data !== e) begin
                    n_fail++;
                    $display("FAIL %s: actual=%h expected=%h", t, out_data, e);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [VW-1:0] ones, r1, r2, held;
        ones = '1;
        rst = 1'b1; in_valid = 1'b0; in_src = '0; in_old = '0; in_mask = '0;
        in_esize = '0; in_vlen = '0; in_mask_en = 1'b0; in_zero = 1'b0; in_bcast = 1'b0;
        repeat (3) @(negedge clk);
        n_run++;
        if (out_valid !== 1'b0 || out_data !== '0) begin
            n_fail++;
            $display("FAIL R11 reset: actual=%b/%h expected=0/0", out_valid, out_data);
        end
        rst = 1'b0;

        // R1 / R2: every size and length, full-ones and random patterns
        for (int sz = 0; sz < 4; sz++) begin
            issue("R1 full ones", ones, '0, '0, sz, 2, 0, 0, 0);
            for (int vl = 0; vl < 4; vl++) begin
                issue("R2 length", rnd512(), rnd512(), 64'(-1), sz, vl, 0, 0, 0);
            end
        end
        idle();

        // R10: single op latency
        issue("R10 single", rnd512(), '0, '0, 0, 2, 0, 0, 0);
        @(negedge clk); in_valid = 1'b0;
        n_run++;
        if (out_valid !== 1'b1) begin
            n_fail++; $display("FAIL R10: actual=%b expected=1", out_valid);
        end
        @(negedge clk);
        n_run++;
        if (out_valid !== 1'b0) begin
            n_fail++; $display("FAIL R10 drop: actual=%b expected=0", out_valid);
        end

        // R11: hold while idle
        held = out_data;
        idle(); idle();
        n_run++;
        if (out_data !== held) begin
            n_fail++; $display("FAIL R11 hold: actual=%h expected=%h", out_data, held);
        end

        // R3: mask disabled, mask bits all clear
        for (int sz = 0; sz < 4; sz++) issue("R3 mask off", rnd512(), ones, '0, sz, 2, 0, 1, 0);

        // R4 / R5: merge and zero with random masks
        for (int sz = 0; sz < 4; sz++) begin
            r1 = rnd512(); r2 = rnd512();
            issue("R4 merge", r1, r2, {$urandom, $urandom}, sz, 2, 1, 0, 0);
            issue("R5 zero",  r1, r2, {$urandom, $urandom}, sz, 2, 1, 1, 0);
        end
        issue("R4 merge all", rnd512(), rnd512(), '0, 1, 2, 1, 0, 0);
        issue("R5 zero all",  rnd512(), rnd512(), '0, 3, 1, 1, 1, 0);

        // R6: broadcast for dword and qword
        for (int vl = 0; vl < 3; vl++) begin
            issue("R6 bcast dword", rnd512(), rnd512(), 64'h5555, 2, vl, 1, 0, 1);
            issue("R6 bcast qword", rnd512(), rnd512(), '0, 3, vl, 0, 0, 1);
        end

        // R7: broadcast ignored for byte and word
        issue("R7 bcast byte", rnd512(), '0, '0, 0, 2, 0, 0, 1);
        issue("R7 bcast word", rnd512(), '0, '0, 1, 1, 0, 0, 1);

        // R8: merge with short length and old all ones
        issue("R8 tail merge", rnd512(), ones, '0, 0, 0, 1, 0, 0);
        issue("R8 tail merge 256", rnd512(), ones, 64'hA, 3, 1, 1, 0, 0);

        // R9: upper mask bits set, only the low lane bits clear
        issue("R9 qword 256", rnd512(), ones, 64'hFFFF_FFFF_FFFF_FFF0, 3, 1, 1, 1, 0);
        issue("R9 dword 128", rnd512(), ones, 64'hFFFF_FFFF_FFFF_FFF5, 2, 0, 1, 0, 0);
        idle(); idle();

        n_run++;
        if (exp_q.size() != 0) begin
            n_fail++; $display("FAIL R10 drain: actual=%0d expected=0", exp_q.size());
        end
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule